// File: doc/BRIEF.md
# Free-Running 64-bit Timer with Self-Rearming Comparator

This block keeps a 64-bit up-counter that advances on a programmable clock divide, and compares it against a 64-bit target value. When the count reaches or passes the target, a sticky event flag is raised. The flag drives an interrupt line through an enable bit. Software owns the flag and clears it.

The comparator can rearm itself. With auto-advance turned on, every matching cycle adds a programmed 32-bit step to the target. This gives a steady train of periodic events, and software never has to rewrite the target.

Everything is reached through a small 32-bit register bus. There is one write strobe, a word address and combinational read data. The 64-bit quantities appear as pairs of 32-bit words, with the low word at the lower address.

Top module: `cmp_timer64`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is low.
- R2: Word address 2 is the control word. Bit 0 runs the counter, bit 1 arms the comparator, bit 2 lets the flag reach `irq_out` and bit 3 turns on auto-advance. Bits 15:8 hold a divide value P. All other bits read 0. While running, the counter gains 1 every P+1 clocks, and the first step lands P+1 clocks after the control write takes effect.
- R3: The word map is: 0 is the count low word, 1 the count high word, 2 control, 3 status, 4 the target low word, 5 the target high word and 6 the step. While bit 0 of control is 0, a write to word 0 or 1 loads that half of the count, and the count then holds.
- R4: The count is one 64-bit value, so a low word that rolls over carries into the high word.
- R5: While bit 0 of control is 1, writes to words 0 and 1 leave the count unchanged.
- R6: With control bit 1 set, status bit 0 is set on the clock after the full 64-bit count first becomes greater than or equal to the 64-bit target.
- R7: Status bit 0 stays set until a bus write to word 3 with bit 0 equal to 1. A write to word 3 with bit 0 equal to 0 leaves the flag unchanged.
- R8: `irq_out` is high exactly when status bit 0 and control bit 2 are both 1.
- R9: With control bits 1 and 3 set, each matching cycle adds the step (word 6, zero-extended) to the target, on the same clock edge that sets the flag.
- R10: With control bit 1 clear, the flag is never set, however far the count runs past the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one clock |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Gated compare event |

## Verification
The bench builds the block with its defaults: 32-bit words, a 64-bit count and an 8-bit divide field. Because the count words can be preloaded while the counter is stopped, the carry from the low word into the high word is reached in a few clocks. The same preloading makes a target whose high word is non-zero reachable in a few clocks, so it can be checked that the comparator looks at the whole 64 bits. A divide value of 2 is used to pin down the exact cycle of every counter step. The auto-advance test follows the target through two consecutive rearms.

// File: rtl/cmp_timer_pkg.sv
// Package: word indexes and control-field positions shared by the timer blocks.
package cmp_timer_pkg;
    localparam int unsigned WORD_CNT_LO = 0;
    localparam int unsigned WORD_CNT_HI = 1;
    localparam int unsigned WORD_CTRL   = 2;
    localparam int unsigned WORD_STAT   = 3;
    localparam int unsigned WORD_TGT_LO = 4;
    localparam int unsigned WORD_TGT_HI = 5;
    localparam int unsigned WORD_STEP   = 6;

    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_ARM  = 1;
    localparam int unsigned CB_IRQ  = 2;
    localparam int unsigned CB_AUTO = 3;
    localparam int unsigned CB_DIV  = 8;
endpackage

// File: rtl/tmr_count_core.sv
// Module: tmr_count_core
// Purpose: the divided free-running up-counter, built from word-wide halves.
// Assumes: word_wr is already decoded. Word writes are honoured only while run_i is low.
module tmr_count_core #(
    parameter int DATA_W = 32,
    parameter int PSC_W  = 8,
    parameter int NWORDS = 2,
    localparam int CNT_W = DATA_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [PSC_W-1:0]  div_i,
    input  logic [NWORDS-1:0] word_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  count_o
);
    logic [PSC_W-1:0] div_cnt_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic             tick;

    // The divide counter reaching div_i marks one count step.
    assign tick = run_i && (div_cnt_q == div_i);

    // The divide counter runs only while counting and restarts on every step.
    always_ff @(posedge clk) begin
        if (!rst_n)          div_cnt_q <= '0;
        else if (!run_i)     div_cnt_q <= '0;
        else if (tick)       div_cnt_q <= '0;
        else                 div_cnt_q <= div_cnt_q + PSC_W'(1);
    end

    // Next count: step while running, otherwise load any written halves.
    always_comb begin
        count_d = count_q;
        if (tick) begin
            count_d = count_q + CNT_W'(1);
        end else if (!run_i) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (word_wr_i[w]) count_d[w*DATA_W +: DATA_W] = wdata_i;
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    // R2, R5: while running, the count moves by at most one per clock and ignores writes.
    assert_step_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)));

    // R3: a stopped counter with no write holds its value.
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && word_wr_i == '0) |=> $stable(count_q));
endmodule

// File: rtl/tmr_match_unit.sv
// Module: tmr_match_unit
// Purpose: holds the 64-bit target and the step, detects count >= target, and keeps the sticky flag.
// Assumes: write strobes are decoded, and a bus write to the target wins over auto-advance.
module tmr_match_unit #(
    parameter int DATA_W = 32,
    parameter int NWORDS = 2,
    localparam int CNT_W = DATA_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              arm_i,
    input  logic              auto_i,
    input  logic [NWORDS-1:0] tgt_wr_i,
    input  logic              step_wr_i,
    input  logic              flag_clr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  target_o,
    output logic [DATA_W-1:0] step_o,
    output logic              flag_o
);
    logic [CNT_W-1:0]  target_q;
    logic [CNT_W-1:0]  target_d;
    logic [DATA_W-1:0] step_q;
    logic              flag_q;
    logic              hit;

    // A hit is an armed comparator with the count at or past the target.
    assign hit = arm_i && (count_i >= target_q);

    // Next target: bus word writes first, otherwise advance by the step on a hit.
    always_comb begin
        target_d = target_q;
        if (tgt_wr_i != '0) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (tgt_wr_i[w]) target_d[w*DATA_W +: DATA_W] = wdata_i;
            end
        end else if (hit && auto_i) begin
            target_d = target_q + CNT_W'(step_q);
        end
    end

    // Target register.
    always_ff @(posedge clk) begin
        if (!rst_n) target_q <= '0;
        else        target_q <= target_d;
    end

    // Step register, written from the bus only.
    always_ff @(posedge clk) begin
        if (!rst_n)         step_q <= '0;
        else if (step_wr_i) step_q <= wdata_i;
    end

    // Sticky flag: a hit sets it, a write of 1 clears it, and a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (hit)        flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    assign target_o = target_q;
    assign step_o   = step_q;
    assign flag_o   = flag_q;

    // R6: an armed comparator whose count reaches the target sets the flag.
    assert_flag_on_reach_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && count_i >= target_q) |=> flag_q);

    // R9: an auto-advance hit with no bus write moves the target up by the step.
    assert_auto_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && auto_i && tgt_wr_i == '0) |=> target_q == $past(target_q) + CNT_W'($past(step_q)));

    // R10: a disarmed comparator never raises the flag.
    assert_disarmed_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !flag_q) |=> !flag_q);

    // R7: a clear with no hit drops the flag.
    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !hit) |=> !flag_q);
endmodule

// File: rtl/tmr_bus_regs.sv
// Module: tmr_bus_regs
// Purpose: decodes bus writes into strobes, owns the control word and muxes the read data.
// Assumes: a word-addressed bus with a one-clock write strobe and combinational reads.
module tmr_bus_regs
    import cmp_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PSC_W  = 8,
    parameter int ADDR_W = 3,
    parameter int NWORDS = 2,
    localparam int CNT_W = DATA_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  target_i,
    input  logic [DATA_W-1:0] step_i,
    input  logic              flag_i,
    output logic              run_o,
    output logic              arm_o,
    output logic              irq_en_o,
    output logic              auto_o,
    output logic [PSC_W-1:0]  div_o,
    output logic [NWORDS-1:0] cnt_wr_o,
    output logic [NWORDS-1:0] tgt_wr_o,
    output logic              step_wr_o,
    output logic              flag_clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic              ctrl_wr;
    logic [3:0]        mode_q;
    logic [PSC_W-1:0]  div_q;
    logic              unused_wbits;

    // One strobe per word of the count and of the target.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word_strobe
        assign cnt_wr_o[w] = wr_en_i && (addr_i == ADDR_W'(WORD_CNT_LO + w));
        assign tgt_wr_o[w] = wr_en_i && (addr_i == ADDR_W'(WORD_TGT_LO + w));
    end

    assign ctrl_wr    = wr_en_i && (addr_i == ADDR_W'(WORD_CTRL));
    assign step_wr_o  = wr_en_i && (addr_i == ADDR_W'(WORD_STEP));
    assign flag_clr_o = wr_en_i && (addr_i == ADDR_W'(WORD_STAT)) && wdata_i[0];

    // Control word: mode bits and the divide value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
        end else if (ctrl_wr) begin
            mode_q <= wdata_i[3:0];
            div_q  <= wdata_i[CB_DIV +: PSC_W];
        end
    end

    assign run_o    = mode_q[CB_RUN];
    assign arm_o    = mode_q[CB_ARM];
    assign irq_en_o = mode_q[CB_IRQ];
    assign auto_o   = mode_q[CB_AUTO];
    assign div_o    = div_q;

    // Write-data bits with no meaning in this module.
    assign unused_wbits = ^{wdata_i[DATA_W-1:CB_DIV+PSC_W], wdata_i[CB_DIV-1:4]};

    // Read mux over the word map.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(WORD_CNT_LO): rdata_o = count_i[0 +: DATA_W];
            ADDR_W'(WORD_CNT_HI): rdata_o = count_i[DATA_W +: DATA_W];
            ADDR_W'(WORD_CTRL): begin
                rdata_o[3:0]              = mode_q;
                rdata_o[CB_DIV +: PSC_W]  = div_q;
            end
            ADDR_W'(WORD_STAT):   rdata_o[0] = flag_i;
            ADDR_W'(WORD_TGT_LO): rdata_o = target_i[0 +: DATA_W];
            ADDR_W'(WORD_TGT_HI): rdata_o = target_i[DATA_W +: DATA_W];
            ADDR_W'(WORD_STEP):   rdata_o = step_i;
            default:              rdata_o = '0;
        endcase
    end

    // R3: a strobe decodes to at most one count word and one target word.
    assert_one_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_wr_o, tgt_wr_o, step_wr_o, ctrl_wr}));
endmodule

// File: rtl/cmp_timer64.sv
// Module: cmp_timer64 (top)
// Purpose: a 64-bit divided up-counter with a self-rearming comparator, on a 32-bit word bus.
// Assumes: one clock domain, synchronous active-low reset, and word-granular accesses.
module cmp_timer64 #(
    parameter int DATA_W = 32,
    parameter int PSC_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int NWORDS = 2;
    localparam int CNT_W  = DATA_W * NWORDS;

    logic              run, arm, irq_en, auto_adv;
    logic [PSC_W-1:0]  div_val;
    logic [NWORDS-1:0] cnt_wr, tgt_wr;
    logic              step_wr, flag_clr, flag;
    logic [CNT_W-1:0]  count, target;
    logic [DATA_W-1:0] step;

    tmr_bus_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr_en), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .count_i(count), .target_i(target), .step_i(step), .flag_i(flag),
        .run_o(run), .arm_o(arm), .irq_en_o(irq_en), .auto_o(auto_adv), .div_o(div_val),
        .cnt_wr_o(cnt_wr), .tgt_wr_o(tgt_wr), .step_wr_o(step_wr), .flag_clr_o(flag_clr),
        .rdata_o(bus_rdata)
    );

    tmr_count_core #(.DATA_W(DATA_W), .PSC_W(PSC_W), .NWORDS(NWORDS)) u_count (
        .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div_val),
        .word_wr_i(cnt_wr), .wdata_i(bus_wdata), .count_o(count)
    );

    tmr_match_unit #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_match (
        .clk(clk), .rst_n(rst_n), .count_i(count), .arm_i(arm), .auto_i(auto_adv),
        .tgt_wr_i(tgt_wr), .step_wr_i(step_wr), .flag_clr_i(flag_clr), .wdata_i(bus_wdata),
        .target_o(target), .step_o(step), .flag_o(flag)
    );

    // Interrupt line: the flag passed through the enable bit.
    assign irq_out = flag & irq_en;

    // R8: with the enable bit clear, the line stays low.
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_out);
endmodule

// File: tb/cmp_timer64_tb_top.sv
// Scoreboard bench: driver tasks queue expected reads, and a monitor compares them mid-cycle.
module cmp_timer64_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2.5 clk = ~clk;

    cmp_timer64 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // Monitor: pops expectations at the falling edge, away from the active edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'd0, irq_out} : bus_rdata;
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: addr %0d actual 0x%08h expected 0x%08h",
                         it.tag, it.addr, act, it.exp);
            end
        end
    end

    // Write one word, in one clock.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    // One idle clock.
    task automatic idle();
        @(posedge clk); #1;
        bus_wr_en = 1'b0;
    endtask

    // Read a word in one clock and queue its expected value.
    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(posedge clk); #1;
        bus_wr_en = 1'b0; bus_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Check the interrupt line in one clock.
    task automatic chk_irq(input logic e, input string tag);
        exp_item_t it;
        @(posedge clk); #1;
        bus_wr_en = 1'b0;
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of all words and of the line.
        for (int a = 0; a < 7; a++) rd(3'(a), 32'h0, "R1");
        chk_irq(1'b0, "R1");

        // R3: stopped counter loads each word.
        wr(3'd0, 32'hFFFF_FFFE);
        wr(3'd1, 32'h0000_0005);
        rd(3'd0, 32'hFFFF_FFFE, "R3");
        rd(3'd1, 32'h0000_0005, "R3");

        // R4: run with divide 0, carry into the high word.
        wr(3'd2, 32'h0000_0001);
        rd(3'd0, 32'hFFFF_FFFE, "R4");
        rd(3'd0, 32'hFFFF_FFFF, "R4");
        rd(3'd0, 32'h0000_0000, "R4");
        rd(3'd1, 32'h0000_0006, "R4");

        // R5: count writes while running are ignored.
        wr(3'd1, 32'h0000_0055);
        rd(3'd1, 32'h0000_0006, "R5");
        rd(3'd0, 32'h0000_0004, "R5");

        // R2: divide by 3 and control readback.
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0000_0201);
        rd(3'd2, 32'h0000_0201, "R2");
        rd(3'd0, 32'd0, "R2");
        rd(3'd0, 32'd0, "R2");
        rd(3'd0, 32'd1, "R2");
        rd(3'd0, 32'd1, "R2");
        rd(3'd0, 32'd1, "R2");
        rd(3'd0, 32'd2, "R2");

        // R6: match at count 10, then R8 the line.
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'd10);
        wr(3'd5, 32'h0);
        wr(3'd2, 32'h0000_0007);
        repeat (10) idle();
        rd(3'd3, 32'd0, "R6");
        rd(3'd3, 32'd1, "R6");
        chk_irq(1'b1, "R8");

        // R8: the flag is set but the enable is off.
        wr(3'd2, 32'h0000_0003);
        chk_irq(1'b0, "R8");
        rd(3'd3, 32'd1, "R8");

        // R7: a write of 0 keeps the flag, a write of 1 clears it.
        wr(3'd2, 32'h0000_0001);
        wr(3'd3, 32'h0);
        rd(3'd3, 32'd1, "R7");
        wr(3'd3, 32'h1);
        rd(3'd3, 32'd0, "R7");

        // R10: disarmed, past the target, no flag.
        repeat (3) idle();
        rd(3'd3, 32'd0, "R10");

        // R6: the full 64-bit compare, with a target of 1_00000000.
        wr(3'd2, 32'h0);
        wr(3'd0, 32'hFFFF_FFF0);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h1);
        wr(3'd2, 32'h0000_0003);
        repeat (16) idle();
        rd(3'd3, 32'd0, "R6");
        rd(3'd3, 32'd1, "R6");

        // R9: auto-advance, target 5 and step 4.
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h1);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'd5);
        wr(3'd5, 32'h0);
        wr(3'd6, 32'd4);
        wr(3'd2, 32'h0000_000F);
        repeat (5) idle();
        rd(3'd4, 32'd5, "R9");
        rd(3'd4, 32'd9, "R9");
        rd(3'd3, 32'd1, "R9");
        idle();
        idle();
        rd(3'd4, 32'd13, "R9");
        rd(3'd5, 32'd0, "R9");
        rd(3'd6, 32'd4, "R9");

        idle();
        @(negedge clk);
        #1;
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule